// File: doc/BRIEF.md
# Predictive Motion Search Sequencer

This block steers the motion search for one 16x16 macroblock at a time. It produces a fixed list of thirteen candidate motion vectors and hands them one by one to an external SAD engine. The engine keeps the running minimum itself. The first five candidates form the predictive phase: the zero vector, two vectors already chosen this frame for neighbouring macroblocks, and two vectors chosen last frame. After that phase the engine returns the winner, V0, together with a flag that says whether the winner's SAD exceeded the engine's threshold. The sequencer then issues eight refinement points around V0. Their diagonal reach depends on that flag. When the engine returns the final best vector, the sequencer records it for later macroblocks and reports it.

Vectors are signed values in half-pixel units. Each macroblock's chosen vector goes into a store with two banks: one bank collects the current frame and the other holds the previous frame. A frame-start pulse swaps the roles of the two banks. Because of this, a vector written during a frame never disturbs the temporal predictors read later in that same frame.

Top module: `pred_mv_sequencer`

## Requirements
- R1: After reset, busy, done and cand_valid are 0 and both store banks read as zero, so every predictor of a macroblock processed before any write is the zero vector.
- R2: The predictive phase issues, in this order: index 0 the zero vector; index 1 the current-frame vector of the left neighbour (column-1); index 2 the current-frame vector of the upper neighbour (row-1); index 3 the previous-frame vector of the same macroblock; index 4 the previous-frame vector of the lower-right neighbour (column+1, row+1). cand_refine is 0 for these.
- R3: A predictor whose macroblock lies outside the 11x9 frame is issued as the zero vector.
- R4: After the fifth candidate is accepted, cand_valid stays low until res_valid. res_mv then becomes V0, and eight refinement candidates follow with cand_refine=1, as (x,y) offsets from V0: (+1,0), (-1,0), (0,+1), (0,-1), (+d,+d), (-d,+d), (+d,-d), (-d,-d).
- R5: d is 2 half-pixels when res_over was 0 at V0 delivery and 6 when it was 1.
- R6: Every candidate component is clamped to the range -32..+31.
- R7: Exactly 13 candidates are issued per macroblock. A candidate stays valid, with an unchanged vector, until cand_ready accepts it. After the 13th, cand_valid stays low.
- R8: The cycle after the final res_valid, done is high for exactly one cycle with out_mv equal to the returned vector. That vector is stored in the current bank at address row*11+column.
- R9: After frame_start, vectors written in the previous frame serve as the temporal predictors, and spatial predictors come from the bank being written now.
- R10: start and frame_start are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Swap bank roles (taken only when idle) |
| start | input | 1 | Begin a macroblock (taken only when idle) |
| mb_col | input | 4 | Macroblock column, 0..10 |
| mb_row | input | 4 | Macroblock row, 0..8 |
| busy | output | 1 | A macroblock is in progress |
| cand_valid | output | 1 | Candidate vector offered |
| cand_ready | input | 1 | SAD engine accepts the candidate |
| cand_refine | output | 1 | Candidate belongs to the refinement phase |
| cand_mv_x | output | 7 | Candidate horizontal component, signed half-pixels |
| cand_mv_y | output | 7 | Candidate vertical component, signed half-pixels |
| res_valid | input | 1 | Engine returns the best vector of a phase |
| res_mv_x | input | 7 | Returned horizontal component |
| res_mv_y | input | 7 | Returned vertical component |
| res_over | input | 1 | Returned SAD exceeded the threshold |
| done | output | 1 | One-cycle completion pulse |
| out_mv_x | output | 7 | Final horizontal component |
| out_mv_y | output | 7 | Final vertical component |

## Verification
The hardest situation to reach is a change of bank role: a temporal predictor must come from the frame before, while the spatial ones come from the bank being written now. A wrong swap only shows up one full frame later. The stimulus processes several complete frames in raster order with random vectors. It also injects frame_start and start pulses while a macroblock is in flight. A bench model of both banks, including the stale contents of the recycled bank, predicts every candidate. Directed macroblocks at the frame edges and V0 values at the range limits cover the zero substitution and the clamping.

// File: rtl/psq_pkg.sv
`timescale 1ns/1ps
package psq_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_PRED,
      S_WAIT_V0,
      S_REF,
      S_WAIT_FIN
   } seq_state_e;

   localparam int N_PRED = 5;
   localparam int N_REF  = 8;
   localparam int N_CAND = N_PRED + N_REF;
   localparam int IDX_W  = $clog2(N_CAND + 1);
endpackage

// File: rtl/psq_vec_store.sv
`timescale 1ns/1ps
module psq_vec_store #(
   parameter int COLS           = 11,
   parameter int ROWS           = 9,
   parameter int VEC_W          = 7,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int DEPTH         = COLS * ROWS,
   localparam int AW            = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cur_bank,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  logic signed [VEC_W-1:0] wr_x,
   input  logic signed [VEC_W-1:0] wr_y,
   input  logic                    rd_prev,
   input  logic [AW-1:0]           rd_addr,
   output logic signed [VEC_W-1:0] rd_x,
   output logic signed [VEC_W-1:0] rd_y
);
   localparam int SLOTS = 2 * DEPTH;

   logic [2*VEC_W-1:0] mem [SLOTS];
   int unsigned wi, ri;

   always_comb begin
      wi = (cur_bank ? DEPTH : 0) + int'(wr_addr);
      ri = ((cur_bank ^ rd_prev) ? DEPTH : 0) + int'(rd_addr);
      if (ri < SLOTS) begin
         rd_x = mem[ri][2*VEC_W-1:VEC_W];
         rd_y = mem[ri][VEC_W-1:0];
      end else begin
         rd_x = '0;
         rd_y = '0;
      end
   end

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
            end else if (wr_en && wi < SLOTS) begin
               mem[wi] <= {wr_x, wr_y};
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (wr_en && wi < SLOTS) mem[wi] <= {wr_x, wr_y};
         end
      end
   endgenerate

   // A write never lands outside the frame
   assert_wr_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> int'(wr_addr) < DEPTH);
endmodule

// File: rtl/psq_cand_gen.sv
`timescale 1ns/1ps
module psq_cand_gen
   import psq_pkg::*;
#(
   parameter int COLS      = 11,
   parameter int ROWS      = 9,
   parameter int VEC_W     = 7,
   parameter int MV_MIN    = -32,
   parameter int MV_MAX    = 31,
   parameter int AXIS_STEP = 1,
   parameter int DIAG_NEAR = 2,
   parameter int DIAG_FAR  = 6,
   localparam int COL_W    = $clog2(COLS),
   localparam int ROW_W    = $clog2(ROWS),
   localparam int AW       = $clog2(COLS * ROWS)
) (
   input  logic [IDX_W-1:0]        idx,
   input  logic [COL_W-1:0]        col,
   input  logic [ROW_W-1:0]        row,
   input  logic signed [VEC_W-1:0] v0_x,
   input  logic signed [VEC_W-1:0] v0_y,
   input  logic                    far,
   input  logic signed [VEC_W-1:0] rd_x,
   input  logic signed [VEC_W-1:0] rd_y,
   output logic                    rd_prev,
   output logic [AW-1:0]           rd_addr,
   output logic signed [VEC_W-1:0] cand_x,
   output logic signed [VEC_W-1:0] cand_y
);
   function automatic int clamp_mv(input int v);
      if (v < MV_MIN) return MV_MIN;
      if (v > MV_MAX) return MV_MAX;
      return v;
   endfunction

   int c, r, addr_i, bx, by, ox, oy, d;
   logic use_mem;

   always_comb begin
      c       = int'(col);
      r       = int'(row);
      d       = far ? DIAG_FAR : DIAG_NEAR;
      use_mem = 1'b0;
      rd_prev = 1'b0;
      addr_i  = 0;
      ox      = 0;
      oy      = 0;
      case (int'(idx))
         1: if (c > 0) begin
               use_mem = 1'b1;
               addr_i  = r * COLS + c - 1;
            end
         2: if (r > 0) begin
               use_mem = 1'b1;
               addr_i  = (r - 1) * COLS + c;
            end
         3: begin
               use_mem = 1'b1;
               rd_prev = 1'b1;
               addr_i  = r * COLS + c;
            end
         4: if (c < COLS - 1 && r < ROWS - 1) begin
               use_mem = 1'b1;
               rd_prev = 1'b1;
               addr_i  = (r + 1) * COLS + c + 1;
            end
         5:  ox = AXIS_STEP;
         6:  ox = -AXIS_STEP;
         7:  oy = AXIS_STEP;
         8:  oy = -AXIS_STEP;
         9:  begin ox = d;  oy = d;  end
         10: begin ox = -d; oy = d;  end
         11: begin ox = d;  oy = -d; end
         12: begin ox = -d; oy = -d; end
         default: ;
      endcase
      if (int'(idx) >= N_PRED) begin
         bx = int'(v0_x);
         by = int'(v0_y);
      end else if (use_mem) begin
         bx = int'(rd_x);
         by = int'(rd_y);
      end else begin
         bx = 0;
         by = 0;
      end
      rd_addr = AW'(addr_i);
      cand_x  = VEC_W'(clamp_mv(bx + ox));
      cand_y  = VEC_W'(clamp_mv(by + oy));
   end
endmodule

// File: rtl/psq_seq_ctrl.sv
`timescale 1ns/1ps
module psq_seq_ctrl
   import psq_pkg::*;
#(
   parameter int COLS   = 11,
   parameter int ROWS   = 9,
   parameter int VEC_W  = 7,
   localparam int COL_W = $clog2(COLS),
   localparam int ROW_W = $clog2(ROWS),
   localparam int AW    = $clog2(COLS * ROWS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_start,
   input  logic                    start,
   input  logic [COL_W-1:0]        mb_col,
   input  logic [ROW_W-1:0]        mb_row,
   input  logic                    cand_ready,
   input  logic                    res_valid,
   input  logic signed [VEC_W-1:0] res_x,
   input  logic signed [VEC_W-1:0] res_y,
   input  logic                    res_over,
   output logic                    busy,
   output logic                    cand_valid,
   output logic                    cand_refine,
   output logic [IDX_W-1:0]        idx,
   output logic [COL_W-1:0]        cur_col,
   output logic [ROW_W-1:0]        cur_row,
   output logic signed [VEC_W-1:0] v0_x,
   output logic signed [VEC_W-1:0] v0_y,
   output logic                    far,
   output logic                    cur_bank,
   output logic                    wr_en,
   output logic [AW-1:0]           wr_addr,
   output logic                    done,
   output logic signed [VEC_W-1:0] out_x,
   output logic signed [VEC_W-1:0] out_y
);
   seq_state_e state;
   logic       take;

   assign busy        = (state != S_IDLE);
   assign cand_valid  = (state == S_PRED) || (state == S_REF);
   assign cand_refine = (state == S_REF);
   assign take        = cand_valid && cand_ready;
   assign wr_en       = (state == S_WAIT_FIN) && res_valid;
   assign wr_addr     = AW'(int'(cur_row) * COLS + int'(cur_col));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         idx      <= '0;
         cur_col  <= '0;
         cur_row  <= '0;
         v0_x     <= '0;
         v0_y     <= '0;
         far      <= 1'b0;
         cur_bank <= 1'b0;
         done     <= 1'b0;
         out_x    <= '0;
         out_y    <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: begin
               if (frame_start) cur_bank <= ~cur_bank;
               if (start) begin
                  cur_col <= mb_col;
                  cur_row <= mb_row;
                  idx     <= '0;
                  state   <= S_PRED;
               end
            end
            S_PRED: if (take) begin
               idx <= idx + 1'b1;
               if (int'(idx) == N_PRED - 1) state <= S_WAIT_V0;
            end
            S_WAIT_V0: if (res_valid) begin
               v0_x  <= res_x;
               v0_y  <= res_y;
               far   <= res_over;
               state <= S_REF;
            end
            S_REF: if (take) begin
               idx <= idx + 1'b1;
               if (int'(idx) == N_CAND - 1) state <= S_WAIT_FIN;
            end
            S_WAIT_FIN: if (res_valid) begin
               out_x <= res_x;
               out_y <= res_y;
               done  <= 1'b1;
               state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // Count of candidates accepted since the macroblock began
   logic [IDX_W:0] issued;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     issued <= '0;
      else if (!busy && start)        issued <= '0;
      else if (take)                  issued <= issued + 1'b1;
   end

   assert_thirteen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> int'(issued) == N_CAND);
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cur_bank));
endmodule

// File: rtl/pred_mv_sequencer.sv
`timescale 1ns/1ps
module pred_mv_sequencer
   import psq_pkg::*;
#(
   parameter int MB_COLS        = 11,
   parameter int MB_ROWS        = 9,
   parameter int VEC_W          = 7,
   parameter int MV_MIN         = -32,
   parameter int MV_MAX         = 31,
   parameter int AXIS_STEP      = 1,
   parameter int DIAG_NEAR      = 2,
   parameter int DIAG_FAR       = 6,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int COL_W         = $clog2(MB_COLS),
   localparam int ROW_W         = $clog2(MB_ROWS),
   localparam int AW            = $clog2(MB_COLS * MB_ROWS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    frame_start,
   input  logic                    start,
   input  logic [COL_W-1:0]        mb_col,
   input  logic [ROW_W-1:0]        mb_row,
   output logic                    busy,
   output logic                    cand_valid,
   input  logic                    cand_ready,
   output logic                    cand_refine,
   output logic signed [VEC_W-1:0] cand_mv_x,
   output logic signed [VEC_W-1:0] cand_mv_y,
   input  logic                    res_valid,
   input  logic signed [VEC_W-1:0] res_mv_x,
   input  logic signed [VEC_W-1:0] res_mv_y,
   input  logic                    res_over,
   output logic                    done,
   output logic signed [VEC_W-1:0] out_mv_x,
   output logic signed [VEC_W-1:0] out_mv_y
);
   initial begin : elab_checks
      assert (MB_COLS > 1 && MB_ROWS > 1)
         else $fatal(1, "frame needs at least 2x2 macroblocks");
      assert (MV_MIN < 0 && MV_MAX > 0)
         else $fatal(1, "vector range must contain zero");
      assert (MV_MAX < 2 ** (VEC_W - 1) && MV_MIN >= -(2 ** (VEC_W - 1)))
         else $fatal(1, "vector range exceeds VEC_W");
      assert (AXIS_STEP > 0 && DIAG_NEAR > 0 && DIAG_NEAR < DIAG_FAR)
         else $fatal(1, "grid steps inconsistent");
   end

   logic [IDX_W-1:0]        idx;
   logic [COL_W-1:0]        cur_col;
   logic [ROW_W-1:0]        cur_row;
   logic signed [VEC_W-1:0] v0_x, v0_y, rd_x, rd_y;
   logic                    far, cur_bank, wr_en, rd_prev;
   logic [AW-1:0]           wr_addr, rd_addr;

   psq_seq_ctrl #(.COLS(MB_COLS), .ROWS(MB_ROWS), .VEC_W(VEC_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .start(start),
      .mb_col(mb_col), .mb_row(mb_row), .cand_ready(cand_ready),
      .res_valid(res_valid), .res_x(res_mv_x), .res_y(res_mv_y), .res_over(res_over),
      .busy(busy), .cand_valid(cand_valid), .cand_refine(cand_refine), .idx(idx),
      .cur_col(cur_col), .cur_row(cur_row), .v0_x(v0_x), .v0_y(v0_y), .far(far),
      .cur_bank(cur_bank), .wr_en(wr_en), .wr_addr(wr_addr), .done(done),
      .out_x(out_mv_x), .out_y(out_mv_y)
   );

   psq_vec_store #(.COLS(MB_COLS), .ROWS(MB_ROWS), .VEC_W(VEC_W),
                   .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk(clk), .rst_n(rst_n), .cur_bank(cur_bank), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_x(res_mv_x), .wr_y(res_mv_y), .rd_prev(rd_prev), .rd_addr(rd_addr),
      .rd_x(rd_x), .rd_y(rd_y)
   );

   psq_cand_gen #(.COLS(MB_COLS), .ROWS(MB_ROWS), .VEC_W(VEC_W), .MV_MIN(MV_MIN),
                  .MV_MAX(MV_MAX), .AXIS_STEP(AXIS_STEP), .DIAG_NEAR(DIAG_NEAR),
                  .DIAG_FAR(DIAG_FAR)) u_gen (
      .idx(idx), .col(cur_col), .row(cur_row), .v0_x(v0_x), .v0_y(v0_y), .far(far),
      .rd_x(rd_x), .rd_y(rd_y), .rd_prev(rd_prev), .rd_addr(rd_addr),
      .cand_x(cand_mv_x), .cand_y(cand_mv_y)
   );

   assert_cand_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid |-> (int'(cand_mv_x) >= MV_MIN && int'(cand_mv_x) <= MV_MAX &&
                      int'(cand_mv_y) >= MV_MIN && int'(cand_mv_y) <= MV_MAX));
   assert_cand_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid && !cand_ready |=> cand_valid && $stable(cand_mv_x) && $stable(cand_mv_y));
   assert_no_write_in_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid |-> !wr_en);
endmodule

// File: tb/sim_pred_mv_sequencer.sv
`timescale 1ns/1ps
module sim_pred_mv_sequencer;
   localparam int COLS = 11;
   localparam int ROWS = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 1'b0, start = 1'b0, cand_ready = 1'b0;
   logic res_valid = 1'b0, res_over = 1'b0;
   logic [3:0] mb_col = '0, mb_row = '0;
   logic signed [6:0] res_mv_x = '0, res_mv_y = '0;
   logic busy, cand_valid, cand_refine, done;
   logic signed [6:0] cand_mv_x, cand_mv_y, out_mv_x, out_mv_y;

   int checks = 0, failures = 0;
   int mvx [2][COLS*ROWS];
   int mvy [2][COLS*ROWS];
   int bank = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   pred_mv_sequencer u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .start(start),
      .mb_col(mb_col), .mb_row(mb_row), .busy(busy), .cand_valid(cand_valid),
      .cand_ready(cand_ready), .cand_refine(cand_refine), .cand_mv_x(cand_mv_x),
      .cand_mv_y(cand_mv_y), .res_valid(res_valid), .res_mv_x(res_mv_x),
      .res_mv_y(res_mv_y), .res_over(res_over), .done(done), .out_mv_x(out_mv_x),
      .out_mv_y(out_mv_y)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int clampi(input int v);
      return (v < -32) ? -32 : ((v > 31) ? 31 : v);
   endfunction

   function automatic int rnd_mv();
      return int'($urandom_range(63)) - 32;
   endfunction

   // Expected candidate k for macroblock (c,r)
   function automatic void exp_cand(input int k, input int c, input int r, input int v0x,
                                    input int v0y, input int farf, output int ex, output int ey);
      int d = farf ? 6 : 2;
      int pb = 1 - bank;
      ex = 0; ey = 0;
      case (k)
         1: if (c > 0) begin ex = mvx[bank][r*COLS+c-1]; ey = mvy[bank][r*COLS+c-1]; end
         2: if (r > 0) begin ex = mvx[bank][(r-1)*COLS+c]; ey = mvy[bank][(r-1)*COLS+c]; end
         3: begin ex = mvx[pb][r*COLS+c]; ey = mvy[pb][r*COLS+c]; end
         4: if (c < COLS-1 && r < ROWS-1) begin
               ex = mvx[pb][(r+1)*COLS+c+1]; ey = mvy[pb][(r+1)*COLS+c+1];
            end
         5:  begin ex = v0x + 1; ey = v0y;     end
         6:  begin ex = v0x - 1; ey = v0y;     end
         7:  begin ex = v0x;     ey = v0y + 1; end
         8:  begin ex = v0x;     ey = v0y - 1; end
         9:  begin ex = v0x + d; ey = v0y + d; end
         10: begin ex = v0x - d; ey = v0y + d; end
         11: begin ex = v0x + d; ey = v0y - d; end
         12: begin ex = v0x - d; ey = v0y - d; end
         default: ;
      endcase
      ex = clampi(ex); ey = clampi(ey);
   endfunction

   function automatic string auto_tag(input int k);
      if (k == 3 || k == 4) return "R9";
      if (k < 5)            return "R2";
      if (k < 9)            return "R4";
      return "R5";
   endfunction

   task automatic new_frame();
      @(negedge clk) frame_start = 1'b1;
      @(negedge clk) frame_start = 1'b0;
      bank = 1 - bank;
   endtask

   task automatic run_mb(input int c, input int r, input int v0x, input int v0y,
                         input int farf, input int fx, input int fy,
                         input bit noise, input string grp);
      int ex, ey;
      string tg;
      @(negedge clk);
      start = 1'b1; mb_col = 4'(c); mb_row = 4'(r);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 13; k++) begin
         tg = (grp == "") ? auto_tag(k) : grp;
         if (k == 5) begin
            chk(!cand_valid, "R4", int'(cand_valid), 0);
            res_valid = 1'b1; res_mv_x = 7'(v0x); res_mv_y = 7'(v0y); res_over = farf[0];
            @(negedge clk);
            res_valid = 1'b0; res_mv_x = 7'(rnd_mv()); res_over = $urandom_range(1);
         end
         exp_cand(k, c, r, v0x, v0y, farf, ex, ey);
         for (int s = int'($urandom_range(2)); s > 0; s--) begin
            chk(cand_valid && int'(cand_mv_x) == ex && int'(cand_mv_y) == ey,
                "R7", int'(cand_mv_x), ex);
            if (noise) begin
               start = 1'b1; frame_start = 1'b1; mb_col = 4'($urandom_range(10));
            end
            @(negedge clk);
            start = 1'b0; frame_start = 1'b0;
         end
         chk(cand_valid, tg, int'(cand_valid), 1);
         chk(cand_refine == (k >= 5), tg, int'(cand_refine), int'(k >= 5));
         chk(int'(cand_mv_x) == ex, tg, int'(cand_mv_x), ex);
         chk(int'(cand_mv_y) == ey, tg, int'(cand_mv_y), ey);
         cand_ready = 1'b1;
         @(negedge clk);
         cand_ready = 1'b0;
      end
      chk(!cand_valid && !done, "R7", int'(cand_valid), 0);
      res_valid = 1'b1; res_mv_x = 7'(fx); res_mv_y = 7'(fy);
      @(negedge clk);
      res_valid = 1'b0;
      chk(done == 1'b1, "R8", int'(done), 1);
      chk(int'(out_mv_x) == fx && int'(out_mv_y) == fy, "R8", int'(out_mv_x), fx);
      mvx[bank][r*COLS+c] = fx;
      mvy[bank][r*COLS+c] = fy;
      @(negedge clk);
      chk(done == 1'b0 && !busy, "R8", int'(done), 0);
   endtask

   initial begin
      void'($urandom(32'd20417));
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < COLS*ROWS; i++) begin mvx[b][i] = 0; mvy[b][i] = 0; end
      repeat (3) @(negedge clk);
      chk(!busy && !done && !cand_valid, "R1", int'(busy) + int'(done) + int'(cand_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !cand_valid, "R1", int'(busy) + int'(done) + int'(cand_valid), 0);
      // Predictors of an interior macroblock before any write are zero
      run_mb(5, 5, 3, -4, 0, 7, -9, 1'b0, "R1");
      // Range limits with the far grid
      run_mb(0, 0, 31, -32, 1, 31, -32, 1'b0, "R6");
      run_mb(1, 0, -32, 31, 1, -20, 12, 1'b0, "R6");
      run_mb(2, 0, 30, 30, 0, 5, 5, 1'b0, "R6");
      // Writes and pulses ignored while busy
      run_mb(3, 0, 1, 1, 0, -7, 3, 1'b1, "R10");
      run_mb(4, 0, 0, 0, 1, 9, 9, 1'b0, "R10");
      // Edge macroblocks after a swap
      new_frame();
      run_mb(10, 8, 2, 2, 0, 11, -11, 1'b0, "R3");
      run_mb(0, 3, -2, 5, 1, 4, 4, 1'b0, "R3");
      run_mb(4, 0, 6, -6, 0, -1, 2, 1'b0, "R3");
      run_mb(10, 0, -5, 0, 1, 0, 8, 1'b0, "R3");
      // Full frames in raster order, random vectors and stalls
      for (int f = 0; f < 3; f++) begin
         new_frame();
         for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
               run_mb(c, r, rnd_mv(), rnd_mv(), int'($urandom_range(1)), rnd_mv(), rnd_mv(),
                      ($urandom_range(7) == 0), "");
      end
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         finished = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule